// File: doc/BRIEF.md
# SCSI Controller Sequence-Step Status Logic

This block holds the status and interrupt registers of a SCSI protocol controller whose selection commands run as several steps under an internal step sequencer. A host bus writes a command register to launch a command and reads a small set of status registers. A stub sequencer stands in for the bus engine. Each pulse on `step_done` completes one step. A pulse on `seq_abort` stops the command where it is. The block raises one interrupt per multi-step command, and only when that command ends.

The step the sequencer reached is kept twice. A visible sequence step register is wiped when the host acknowledges the interrupt by reading the interrupt status register. A shadow step counter survives that read and appears in the upper bits of the FIFO flags register. Drivers that poll the FIFO flags for a non-zero value after the acknowledge therefore still see how far the command got. The FIFO is modelled by its byte count only.

No data moves as a stream here. All host traffic is plain single-cycle register reads and writes with no back-pressure. Read data is combinational from `reg_addr` in the same cycle.

Register addresses (`reg_addr`):
- 0: FIFO data port. A write pushes, a read pops, and the read data is zero.
- 1: command register, write only. The opcode is in bits [6:0] and bit 7 is ignored.
- 2: status register.
- 3: interrupt status register.
- 4: sequence step register.
- 5: FIFO flags register.
- 6 and 7: read as zero.

Opcodes:
- 0x00: no operation.
- 0x01: flush FIFO.
- 0x41: select, which completes after 3 steps.
- 0x42: select with attention, which completes after 4 steps.
- Any other opcode is accepted and does nothing.

Top module: `scsi_step_status`

## Requirements
- R1: After reset `irq` is low and the status, interrupt status, sequence step and FIFO flags registers all read 0x00.
- R2: An accepted multi-step opcode (0x41 or 0x42) clears the shadow step bits (FIFO flags [7:5]) and the sequence step register (bits [2:0], bits [7:3] zero) in the cycle it is written. Each later `step_done` pulse adds one to both copies.
- R3: A multi-step command raises `irq` once, in the cycle after its final step pulse (step 3 for 0x41, step 4 for 0x42). When it does, the interrupt status register reads 0x08 (bit 3, function complete). `irq` stays low after each earlier step.
- R4: A `seq_abort` pulse while a command runs raises `irq` the next cycle. The interrupt status then reads 0x10 (bit 4, bus service), status bit 6 is set, and both step copies hold the step reached. `seq_abort` wins over a `step_done` in the same cycle.
- R5: A read of the interrupt status register while `irq` is high returns the pending value in that cycle. From the next cycle `irq` is low, and the interrupt status, status and sequence step registers read 0x00.
- R6: A read of the interrupt status register while `irq` is low changes no register.
- R7: The shadow step bits in FIFO flags [7:5] keep their value across the acknowledging read.
- R8: Opcodes that are not multi-step leave the shadow step bits unchanged. Flush (0x01) sets the FIFO count to zero.
- R9: FIFO flags [4:0] hold the byte count. A push adds one and saturates at 16. A pop removes one and saturates at 0.
- R10: While a command runs, command register writes are ignored. While idle, `step_done` and `seq_abort` are ignored.
- R11: Status register bit 7 equals `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| step_done | input | 1 | Sequencer step-complete pulse |
| seq_abort | input | 1 | Sequencer stop pulse |
| irq | output | 1 | Interrupt line |

## Verification
The main function is tried with two patterns:
- A full select-with-attention run, which must interrupt only after the fourth pulse. This separates a per-step interrupt from a single end interrupt.
- A select stopped by an abort after one step, which separates the function-complete and bus-service codes and shows that the step reached is held.

After each acknowledge, the sequence step register is compared with the FIFO flags. This tells a shadow counter that survives from one that is wiped along with the visible register.

Stray strokes are also applied: steps while idle, commands while busy, a second acknowledge, a flush and a no-op. These show which events may touch the shadow bits. Long push and pop runs reach both count limits.

// File: rtl/scsi_step_pkg.sv
package scsi_step_pkg;

  typedef enum logic [2:0] {
    A_FIFO  = 3'd0,
    A_CMD   = 3'd1,
    A_STAT  = 3'd2,
    A_ISTAT = 3'd3,
    A_SEQ   = 3'd4,
    A_FLAGS = 3'd5
  } reg_addr_e;

  localparam logic [6:0] OP_NOP     = 7'h00;
  localparam logic [6:0] OP_FLUSH   = 7'h01;
  localparam logic [6:0] OP_SEL     = 7'h41;
  localparam logic [6:0] OP_SEL_ATN = 7'h42;

  function automatic logic op_is_multi(input logic [6:0] op);
    return (op == OP_SEL) || (op == OP_SEL_ATN);
  endfunction

endpackage

// File: rtl/scsi_fifo_level.sv
module scsi_fifo_level #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o <= '0;
    end else if (flush_i) begin
      count_o <= '0;
    end else if (push_i && count_o != FULL) begin
      count_o <= count_o + CNT_W'(1);
    end else if (pop_i && count_o != '0) begin
      count_o <= count_o - CNT_W'(1);
    end
  end
endmodule

// File: rtl/scsi_step_seq.sv
module scsi_step_seq #(
  parameter int STEP_W    = 3,
  parameter int SEL_STEPS = 3,
  parameter int ATN_STEPS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              atn_i,
  input  logic              step_i,
  input  logic              abort_i,
  output logic              busy_o,
  output logic [STEP_W-1:0] ss_o,
  output logic              step_evt_o,
  output logic [STEP_W-1:0] step_val_o,
  output logic              fin_o,
  output logic              stop_o
);
  localparam logic [STEP_W-1:0] SEL_T = STEP_W'(SEL_STEPS);
  localparam logic [STEP_W-1:0] ATN_T = STEP_W'(ATN_STEPS);

  logic [STEP_W-1:0] target_q;

  always_comb begin
    step_val_o = ss_o + STEP_W'(1);
    step_evt_o = busy_o && step_i && !abort_i;
    fin_o      = step_evt_o && (step_val_o == target_q);
    stop_o     = busy_o && abort_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o   <= 1'b0;
      ss_o     <= '0;
      target_q <= '0;
    end else if (start_i) begin
      busy_o   <= 1'b1;
      ss_o     <= '0;
      target_q <= atn_i ? ATN_T : SEL_T;
    end else begin
      if (step_evt_o) ss_o <= step_val_o;
      if (fin_o || stop_o) busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/scsi_irq_regs.sv
module scsi_irq_regs #(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              ack_i,
  input  logic              step_evt_i,
  input  logic [STEP_W-1:0] step_val_i,
  input  logic              fin_i,
  input  logic              stop_i,
  output logic              irq_o,
  output logic              func_done_o,
  output logic              bus_svc_o,
  output logic              aborted_o,
  output logic [STEP_W-1:0] seq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o       <= 1'b0;
      func_done_o <= 1'b0;
      bus_svc_o   <= 1'b0;
      aborted_o   <= 1'b0;
      seq_o       <= '0;
    end else begin
      if (ack_i) begin
        irq_o       <= 1'b0;
        func_done_o <= 1'b0;
        bus_svc_o   <= 1'b0;
        aborted_o   <= 1'b0;
        seq_o       <= '0;
      end
      if (start_i) seq_o <= '0;
      if (step_evt_i) seq_o <= step_val_i;
      if (fin_i) begin
        irq_o       <= 1'b1;
        func_done_o <= 1'b1;
      end
      if (stop_i) begin
        irq_o     <= 1'b1;
        bus_svc_o <= 1'b1;
        aborted_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/scsi_step_status.sv
module scsi_step_status
  import scsi_step_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int STEP_W     = 3,
  parameter int SEL_STEPS  = 3,
  parameter int ATN_STEPS  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       step_done,
  input  logic       seq_abort,
  output logic       irq
);
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
  localparam int FLAG_W = STEP_W + CNT_W;

  logic [6:0]        opcode;
  logic              cmd_take, start, flush, push, pop, ack;
  logic              busy, step_evt, fin, stop;
  logic [STEP_W-1:0] ss, step_val, seq;
  logic              func_done, bus_svc, aborted;
  logic [CNT_W-1:0]  count;
  logic [FLAG_W-1:0] flags;
  reg_addr_e         addr_e;

  always_comb begin
    addr_e   = reg_addr_e'(reg_addr);
    opcode   = reg_wdata[6:0];
    cmd_take = reg_wr && (addr_e == A_CMD) && !busy;
    start    = cmd_take && op_is_multi(opcode);
    flush    = cmd_take && (opcode == OP_FLUSH);
    push     = reg_wr && !reg_rd && (addr_e == A_FIFO);
    pop      = reg_rd && !reg_wr && (addr_e == A_FIFO);
    ack      = reg_rd && (addr_e == A_ISTAT) && irq;
    flags    = {ss, count};
  end

  scsi_fifo_level #(.DEPTH(FIFO_DEPTH)) u_level (
    .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
    .flush_i(flush), .count_o(count)
  );

  scsi_step_seq #(.STEP_W(STEP_W), .SEL_STEPS(SEL_STEPS), .ATN_STEPS(ATN_STEPS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .atn_i(opcode == OP_SEL_ATN),
    .step_i(step_done), .abort_i(seq_abort), .busy_o(busy), .ss_o(ss),
    .step_evt_o(step_evt), .step_val_o(step_val), .fin_o(fin), .stop_o(stop)
  );

  scsi_irq_regs #(.STEP_W(STEP_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ack_i(ack),
    .step_evt_i(step_evt), .step_val_i(step_val), .fin_i(fin), .stop_i(stop),
    .irq_o(irq), .func_done_o(func_done), .bus_svc_o(bus_svc),
    .aborted_o(aborted), .seq_o(seq)
  );

  always_comb begin
    unique case (addr_e)
      A_STAT:  reg_rdata = {irq, aborted, 6'b0};
      A_ISTAT: reg_rdata = {3'b0, bus_svc, func_done, 3'b0};
      A_SEQ:   reg_rdata = 8'(seq);
      A_FLAGS: reg_rdata = 8'(flags);
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/scsi_step_status_chk.sv
module scsi_step_status_chk #(
  parameter int FIFO_DEPTH = 16,
  parameter int STEP_W     = 3,
  parameter int CNT_W      = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              busy,
  input logic              start,
  input logic              ack,
  input logic              step_evt,
  input logic              stop,
  input logic              func_done,
  input logic              bus_svc,
  input logic [STEP_W-1:0] ss,
  input logic [STEP_W-1:0] seq,
  input logic [CNT_W-1:0]  count
);
  assert_irq_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(busy) && !busy));

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !step_evt && !stop && !start) |=> (!irq && seq == '0 && !func_done && !bus_svc));

  assert_shadow_survives_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !busy && !start) |=> $stable(ss));

  assert_idle_shadow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(ss));

  assert_step_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (seq == ss));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(FIFO_DEPTH));
endmodule

bind scsi_step_status scsi_step_status_chk #(
  .FIFO_DEPTH(FIFO_DEPTH), .STEP_W(STEP_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .busy(busy), .start(start), .ack(ack),
  .step_evt(step_evt), .stop(stop), .func_done(func_done), .bus_svc(bus_svc),
  .ss(ss), .seq(seq), .count(count)
);

// File: tb/scsi_step_status_test.sv
module scsi_step_status_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       step_done = 1'b0, seq_abort = 1'b0;
  logic       irq;

  int errors = 0, checks = 0;
  bit done = 0;

  // reference model state
  bit m_busy, m_irq, m_fc, m_bs, m_ab;
  int m_target, m_ss, m_seq, m_cnt;

  always #2 clk = ~clk;

  scsi_step_status uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .step_done(step_done), .seq_abort(seq_abort), .irq(irq)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_irq = 0; m_fc = 0; m_bs = 0; m_ab = 0;
      m_target = 0; m_ss = 0; m_seq = 0; m_cnt = 0;
    end else begin
      bit stepped;
      stepped = 0;
      if (reg_rd && reg_addr == 3 && m_irq) begin
        m_irq = 0; m_fc = 0; m_bs = 0; m_ab = 0; m_seq = 0;
      end
      if (reg_wr && !reg_rd && reg_addr == 0 && m_cnt < 16) m_cnt++;
      if (reg_rd && !reg_wr && reg_addr == 0 && m_cnt > 0) m_cnt--;
      if (m_busy) begin
        if (seq_abort) begin
          m_busy = 0; m_irq = 1; m_bs = 1; m_ab = 1;
        end else if (step_done) begin
          m_ss++; m_seq = m_ss;
          if (m_ss == m_target) begin
            m_busy = 0; m_irq = 1; m_fc = 1;
          end
        end
      end else if (reg_wr && reg_addr == 1) begin
        case (reg_wdata[6:0])
          7'h01: m_cnt = 0;
          7'h41: begin m_busy = 1; m_target = 3; m_ss = 0; m_seq = 0; end
          7'h42: begin m_busy = 1; m_target = 4; m_ss = 0; m_seq = 0; end
          default: ;
        endcase
      end
      if (stepped) m_seq = m_seq;
    end
  end

  function automatic int model_reg(input int a);
    case (a)
      2: return (int'(m_irq) << 7) | (int'(m_ab) << 6);
      3: return (int'(m_bs) << 4) | (int'(m_fc) << 3);
      4: return m_seq;
      5: return (m_ss << 5) | m_cnt;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the interrupt line
  always @(negedge clk) begin
    if (rst_n && !done) check(irq == m_irq, "R3 irq vs model", irq, m_irq);
  end

  task automatic peek(input int a, output int v);
    reg_addr = 3'(a); reg_rd = 0;
    #1 v = reg_rdata;
  endtask

  task automatic expect_reg(input int a, input string tag);
    int v;
    peek(a, v);
    check(v == model_reg(a), tag, v, model_reg(a));
  endtask

  task automatic expect_lit(input int a, input int exp, input string tag);
    int v;
    peek(a, v);
    check(v == exp, tag, v, exp);
    check(v == model_reg(a), {tag, " model"}, v, model_reg(a));
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_addr = 3'(a); reg_wdata = 8'(d); reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    reg_addr = 3'(a); reg_rd = 1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic pulse_step();
    @(negedge clk); step_done = 1;
    @(negedge clk); step_done = 0;
  endtask

  task automatic pulse_abort();
    @(negedge clk); seq_abort = 1;
    @(negedge clk); seq_abort = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check(irq == 0, "R1 irq after reset", irq, 0);
    for (int a = 2; a <= 5; a++) expect_lit(a, 0, "R1 reset register");

    // R9 simple pushes and pops
    wr(0, 8'hA5); wr(0, 8'h5A); wr(0, 8'h11);
    expect_lit(5, 3, "R9 count after three pushes");
    rd(0, v);
    expect_lit(5, 2, "R9 count after pop");

    // R2 R3 select with attention, four steps
    wr(1, 8'h42);
    expect_lit(5, 2, "R2 shadow cleared at start");
    expect_lit(4, 0, "R2 seq step cleared at start");
    for (int s = 1; s <= 3; s++) begin
      pulse_step();
      expect_lit(4, s, "R2 seq step after step");
      expect_lit(5, (s << 5) | 2, "R2 shadow after step");
      check(irq == 0, "R3 no interrupt before last step", irq, 0);
    end
    pulse_step();
    check(irq == 1, "R3 interrupt after final step", irq, 1);
    expect_lit(3, 8'h08, "R3 function complete code");
    expect_lit(2, 8'h80, "R11 status bit7 mirrors irq");
    expect_lit(4, 4, "R2 seq step at end");

    // R5 R7 acknowledge
    rd(3, v);
    check(v == 8'h08, "R5 ack read returns pending value", v, 8'h08);
    check(irq == 0, "R5 irq dropped after ack", irq, 0);
    expect_lit(3, 0, "R5 istat cleared");
    expect_lit(2, 0, "R5 status cleared");
    expect_lit(4, 0, "R5 seq step cleared");
    expect_lit(5, (4 << 5) | 2, "R7 shadow survives ack");

    // R6 read while irq low
    rd(3, v);
    check(v == 0, "R6 idle istat read value", v, 0);
    expect_lit(5, (4 << 5) | 2, "R6 no side effect on flags");
    expect_lit(4, 0, "R6 no side effect on seq step");

    // R8 non multi-step commands
    wr(1, 8'h00);
    expect_lit(5, (4 << 5) | 2, "R8 nop keeps shadow");
    wr(1, 8'h01);
    expect_lit(5, (4 << 5), "R8 flush zeroes count keeps shadow");
    wr(1, 8'h7F);
    expect_lit(5, (4 << 5), "R8 unknown opcode keeps shadow");

    // R10 idle strobes ignored
    pulse_step(); pulse_abort();
    check(irq == 0, "R10 idle abort ignored", irq, 0);
    expect_lit(5, (4 << 5), "R10 idle step ignored");

    // R4 abort after one step
    wr(1, 8'h41);
    pulse_step();
    @(negedge clk); step_done = 1; seq_abort = 1;
    @(negedge clk); step_done = 0; seq_abort = 0;
    check(irq == 1, "R4 interrupt on abort", irq, 1);
    expect_lit(3, 8'h10, "R4 bus service code");
    expect_lit(2, 8'hC0, "R4 status aborted bit");
    expect_lit(4, 1, "R4 seq step held");
    expect_lit(5, (1 << 5), "R4 shadow held");
    rd(3, v);
    check(v == 8'h10, "R5 ack returns abort code", v, 8'h10);
    expect_lit(5, (1 << 5), "R7 shadow survives ack after abort");

    // R10 commands while busy ignored
    wr(0, 1);
    wr(1, 8'h41);
    wr(1, 8'h42);
    wr(1, 8'h01);
    expect_lit(5, 1, "R10 flush ignored while busy");
    pulse_step(); pulse_step();
    check(irq == 0, "R10 target kept from first command", irq, 0);
    pulse_step();
    check(irq == 1, "R10 select ends after three steps", irq, 1);
    expect_lit(5, (3 << 5) | 1, "R2 shadow at three");
    rd(3, v);

    // R9 saturation
    for (int i = 0; i < 20; i++) wr(0, i);
    expect_lit(5, (3 << 5) | 16, "R9 saturate at 16");
    for (int i = 0; i < 20; i++) rd(0, v);
    expect_lit(5, (3 << 5), "R9 saturate at 0");
    for (int a = 2; a <= 4; a++) expect_reg(a, "R5 final register state");

    finish_run();
  end
endmodule